// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of month, weekday, month and a two-digit year. It moves forward by one second on each pulse of a one-per-second tick input. The hours byte can be read and advanced in either a 24-hour form or a 12-hour form that carries a PM marker. Month lengths and leap Februaries are handled inside the block.

A host reaches the counters through a plain byte-wide register port. The port has an address, a write strobe and write data, and the read data is combinational. A control byte holds the hour-format select and a run/stop bit. An oscillator-failure input sets a sticky integrity flag, which the host sees in the top bit of the seconds byte. The flag clears only when the host rewrites seconds with that bit low.

A one-cycle strobe marks each minute boundary, so a neighbouring alarm comparator can evaluate once per minute.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read as follows: seconds 0x80 (integrity flag set, count 00), minutes 0x00, hours 0x00, date 0x01, weekday 0x00, month 0x01, year 0x00 and control 0x00.
- R2: The address map is 0x00 for control, where bit 3 selects 12-hour mode and bit 5 is stop, and all other control bits read 0. Addresses 0x03 to 0x09 hold seconds, minutes, hours, date, weekday, month and year in that order. Writes keep only the field bits: seconds 6:0, minutes 6:0, hours 5:0, date 5:0, weekday 2:0, month 4:0 and year 7:0. Every other address reads 0x00, and writes to those addresses change nothing.
- R3: On a tick with stop clear, seconds increments in BCD. At 59 it wraps to 00 and minutes increments, and minutes likewise wraps from 59 to 00 with a carry into hours.
- R4: In 24-hour mode, hours wraps from 0x23 to 0x00 and carries into the date.
- R5: In 12-hour mode, hours is BCD 01 to 12 in bits 4:0, and bit 5 set means PM. Going from 11 to 12 flips the PM bit, and going from 12 to 01 keeps it. The step from 11 PM to 12 AM carries into the date.
- R6: When the date equals the length of its month, it returns to 01 and the month increments. April, June, September and November have 30 days, and the other months except February have 31. Month 12 goes back to 01 and increments the year, and year 99 goes back to 00.
- R7: February has 29 days when the two-digit year is divisible by 4, and 28 days otherwise.
- R8: Weekday counts 0 to 6, advances on every date carry, and goes from 6 back to 0.
- R9: While the stop bit is set, ticks have no effect on any time register.
- R10: A high oscillator-failure input sets the integrity flag, and the flag stays set. A host write to seconds loads the flag from wdata bit 7. A failure input in the same cycle as that write wins.
- R11: The minute strobe is high for exactly the one cycle in which seconds first reads 00 after a tick-driven wrap from 59.
- R12: A host write to any time register in the same cycle as a tick discards that tick for the whole counter. Only the written field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| osc_fail | input | 1 | Oscillator stopped or interrupted |
| wr_en | input | 1 | Host write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for addr (combinational) |
| minute_strobe | output | 1 | One-cycle pulse when seconds wraps to 00 |

## Verification
Several properties are checked on every cycle:
- the minute strobe is high only while seconds is 00;
- a set stop bit with no host write leaves all seven fields unchanged;
- a failure input always sets the integrity flag;
- each date carry lands on day 01 and wraps weekday 6 to 0.

Other behaviours only show up in the bench's scenarios:
- the lengths of individual months and the leap rule;
- the 12-hour PM transitions;
- write masking;
- the discarded tick when a write collides with it;
- complete rollovers such as the last second of year 99.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] bcd8_t;

  // register addresses
  localparam int ADR_CTRL = 0;
  localparam int ADR_SEC  = 3;
  localparam int ADR_MIN  = 4;
  localparam int ADR_HOUR = 5;
  localparam int ADR_DATE = 6;
  localparam int ADR_WDAY = 7;
  localparam int ADR_MON  = 8;
  localparam int ADR_YEAR = 9;

  localparam int CTRL_MODE12_BIT = 3;
  localparam int CTRL_STOP_BIT   = 5;

  function automatic logic [6:0] bcd2bin(input bcd8_t v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // R6 R7: month length in BCD
  function automatic bcd8_t month_len(input bcd8_t mon, input bcd8_t yr);
    logic [6:0] yb;
    yb = bcd2bin(yr);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_cal_wrap60.sv
// R3: one BCD modulo-60 stage (seconds or minutes)
module bcd_cal_wrap60
  import bcd_cal_pkg::*;
(
  input  bcd8_t cur,
  input  logic  inc,
  output bcd8_t nxt,
  output logic  wrap
);
  localparam bcd8_t TOP = 8'h59;

  always_comb begin
    wrap = inc && (cur >= TOP);
    if (!inc)      nxt = cur;
    else if (wrap) nxt = 8'h00;
    else           nxt = bcd_inc(cur);
  end
endmodule

// File: rtl/bcd_cal_hour_step.sv
// R4 R5: hour advance in 24-hour or 12-hour encoding
module bcd_cal_hour_step
  import bcd_cal_pkg::*;
(
  input  bcd8_t hour,
  input  logic  mode12,
  input  logic  inc,
  output bcd8_t nxt,
  output logic  day_carry
);
  logic       pm;
  logic [4:0] h12;

  always_comb begin
    pm        = hour[5];
    h12       = hour[4:0];
    nxt       = hour;
    day_carry = 1'b0;
    if (inc) begin
      if (!mode12) begin
        if (hour >= 8'h23) begin
          nxt       = 8'h00;
          day_carry = 1'b1;
        end else begin
          nxt = bcd_inc(hour);
        end
      end else begin
        if (h12 == 5'h12) begin
          nxt = {2'b00, pm, 5'h01};
        end else if (h12 == 5'h11) begin
          nxt       = {2'b00, ~pm, 5'h12};
          day_carry = pm;
        end else begin
          nxt = {2'b00, pm, 5'(bcd_inc({3'b000, h12}))};
        end
      end
    end
  end
endmodule

// File: rtl/bcd_cal_date_step.sv
// R6 R7 R8: date, weekday, month and year advance
module bcd_cal_date_step
  import bcd_cal_pkg::*;
(
  input  bcd8_t date,
  input  bcd8_t wday,
  input  bcd8_t mon,
  input  bcd8_t yr,
  input  logic  inc,
  output bcd8_t date_nx,
  output bcd8_t wday_nx,
  output bcd8_t mon_nx,
  output bcd8_t yr_nx,
  output logic  day_roll
);
  logic mon_roll;

  always_comb begin
    day_roll = inc && (date >= month_len(mon, yr));
    mon_roll = day_roll && (mon >= 8'h12);
    date_nx  = !inc ? date : (day_roll ? 8'h01 : bcd_inc(date));
    wday_nx  = !inc ? wday : ((wday >= 8'h06) ? 8'h00 : wday + 8'h01);
    mon_nx   = !day_roll ? mon : (mon_roll ? 8'h01 : bcd_inc(mon));
    if (!mon_roll)          yr_nx = yr;
    else if (yr >= 8'h99)   yr_nx = 8'h00;
    else                    yr_nx = bcd_inc(yr);
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              osc_fail,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              minute_strobe
);
  localparam int N_STAGE60 = 2;  // seconds, minutes

  bcd8_t sec_q, min_q, hour_q, date_q, wday_q, mon_q, yr_q;
  logic  osc_q, mode12_q, stop_q, strobe_q;

  // named internal events
  logic  wr_time, advance, sec_wrap, min_wrap, day_carry, day_roll;
  bcd8_t hour_nx, date_nx, wday_nx, mon_nx, yr_nx;

  logic [N_STAGE60-1:0][7:0] st_cur, st_nx;
  logic [N_STAGE60-1:0]      st_inc, st_wrap;

  // R12: any write to a time register discards a coincident tick
  assign wr_time = wr_en && (addr >= ADDR_W'(ADR_SEC)) && (addr <= ADDR_W'(ADR_YEAR));
  assign advance = tick_1hz && !stop_q && !wr_time;

  assign st_cur = {min_q, sec_q};
  assign st_inc = {st_wrap[0], advance};

  for (genvar g = 0; g < N_STAGE60; g++) begin : g_wrap60
    bcd_cal_wrap60 u_stage (
      .cur (st_cur[g]),
      .inc (st_inc[g]),
      .nxt (st_nx[g]),
      .wrap(st_wrap[g])
    );
  end

  assign sec_wrap = st_wrap[0];
  assign min_wrap = st_wrap[1];

  bcd_cal_hour_step u_hour (
    .hour     (hour_q),
    .mode12   (mode12_q),
    .inc      (min_wrap),
    .nxt      (hour_nx),
    .day_carry(day_carry)
  );

  bcd_cal_date_step u_date (
    .date    (date_q),
    .wday    (wday_q),
    .mon     (mon_q),
    .yr      (yr_q),
    .inc     (day_carry),
    .date_nx (date_nx),
    .wday_nx (wday_nx),
    .mon_nx  (mon_nx),
    .yr_nx   (yr_nx),
    .day_roll(day_roll)
  );

  // R1 R2 R3 R9 R10 R11 R12
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q    <= 8'h00;
      min_q    <= 8'h00;
      hour_q   <= 8'h00;
      date_q   <= 8'h01;
      wday_q   <= 8'h00;
      mon_q    <= 8'h01;
      yr_q     <= 8'h00;
      osc_q    <= 1'b1;
      mode12_q <= 1'b0;
      stop_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= sec_wrap;
      if (wr_en && addr == ADDR_W'(ADR_CTRL)) begin
        mode12_q <= wdata[CTRL_MODE12_BIT];
        stop_q   <= wdata[CTRL_STOP_BIT];
      end
      if (wr_en && addr == ADDR_W'(ADR_SEC)) osc_q <= wdata[7] | osc_fail;
      else if (osc_fail)                     osc_q <= 1'b1;
      if (wr_time) begin
        case (addr)
          ADDR_W'(ADR_SEC):  sec_q  <= {1'b0, wdata[6:0]};
          ADDR_W'(ADR_MIN):  min_q  <= {1'b0, wdata[6:0]};
          ADDR_W'(ADR_HOUR): hour_q <= {2'b00, wdata[5:0]};
          ADDR_W'(ADR_DATE): date_q <= {2'b00, wdata[5:0]};
          ADDR_W'(ADR_WDAY): wday_q <= {5'b00000, wdata[2:0]};
          ADDR_W'(ADR_MON):  mon_q  <= {3'b000, wdata[4:0]};
          default:           yr_q   <= wdata;
        endcase
      end else if (advance) begin
        sec_q  <= st_nx[0];
        min_q  <= st_nx[1];
        hour_q <= hour_nx;
        date_q <= date_nx;
        wday_q <= wday_nx;
        mon_q  <= mon_nx;
        yr_q   <= yr_nx;
      end
    end
  end

  // R2: read mux
  always_comb begin
    case (addr)
      ADDR_W'(ADR_CTRL): rdata = 8'(({7'd0, stop_q} << CTRL_STOP_BIT) |
                                   ({7'd0, mode12_q} << CTRL_MODE12_BIT));
      ADDR_W'(ADR_SEC):  rdata = {osc_q, sec_q[6:0]};
      ADDR_W'(ADR_MIN):  rdata = min_q;
      ADDR_W'(ADR_HOUR): rdata = hour_q;
      ADDR_W'(ADR_DATE): rdata = date_q;
      ADDR_W'(ADR_WDAY): rdata = wday_q;
      ADDR_W'(ADR_MON):  rdata = mon_q;
      ADDR_W'(ADR_YEAR): rdata = yr_q;
      default:           rdata = 8'h00;
    endcase
  end

  assign minute_strobe = strobe_q;

  // R11
  strobe_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    minute_strobe |-> (sec_q == 8'h00));

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
                            $stable(date_q) && $stable(wday_q) && $stable(mon_q) &&
                            $stable(yr_q)));

  // R10
  osc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> osc_q);

  // R6
  day_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |=> (date_q == 8'h01));

  // R8
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && wday_q == 8'h06) |=> (wday_q == 8'h00));
endmodule

// File: tb/bcd_calendar_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_tb_top;
  localparam int ADDR_W = 5;
  localparam real CLK_HALF = 2.5;

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, osc_fail = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = 8'h00, rdata;
  logic minute_strobe;
  int checks = 0, errors = 0;

  always #(CLK_HALF) clk = ~clk;

  bcd_calendar #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_fail(osc_fail),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .minute_strobe(minute_strobe)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); addr = ADDR_W'(a); #1 d = rdata;
  endtask

  task automatic tick1();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  // time in binary, hour already encoded as a byte by the caller
  task automatic set_time(input int s, input int m, input logic [7:0] h, input int d,
                          input int w, input int mo, input int y);
    wr(3, to_bcd(s)); wr(4, to_bcd(m)); wr(5, h); wr(6, to_bcd(d));
    wr(7, to_bcd(w)); wr(8, to_bcd(mo)); wr(9, to_bcd(y));
  endtask

  task automatic rd_all(output logic [63:0] v);
    logic [7:0] b;
    v = '0;
    for (int a = 3; a <= 9; a++) begin
      rd(a, b);
      v = {v[55:0], b};
    end
  endtask

  function automatic logic [63:0] pack(input int s, input int m, input logic [7:0] h,
                                       input int d, input int w, input int mo, input int y);
    return {8'h00, to_bcd(s), to_bcd(m), h, to_bcd(d), to_bcd(w), to_bcd(mo), to_bcd(y)};
  endfunction

  initial begin
    #(CLK_HALF * 2 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [7:0] b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_all(v);
    chk("R1 time regs", v, 64'h0080_0000_0100_0100);
    rd(0, b); chk("R1 control", b, 8'h00);

    // R2 masking and unmapped addresses
    wr(0, 8'hFF); rd(0, b); chk("R2 control mask", b, 8'h28);
    wr(0, 8'h00);
    wr(7, 8'hFF); rd(7, b); chk("R2 weekday mask", b, 8'h07);
    wr(3, 8'h15);
    wr(1, 8'h12); rd(1, b); chk("R2 unmapped reads 0", b, 8'h00);
    rd(3, b); chk("R2 unmapped write ignored", b, 8'h15);
    rd(10, b); chk("R2 addr 0x0A reads 0", b, 8'h00);

    // R10 integrity flag
    wr(3, 8'h00); rd(3, b); chk("R10 write clears", b, 8'h00);
    @(negedge clk); osc_fail = 1'b1; @(negedge clk); osc_fail = 1'b0;
    rd(3, b); chk("R10 fail sets", b, 8'h80);
    tick1(); rd(3, b); chk("R10 stays set across tick", b, 8'h81);
    @(negedge clk); addr = 5'd3; wdata = 8'h15; wr_en = 1'b1; osc_fail = 1'b1;
    @(negedge clk); wr_en = 1'b0; osc_fail = 1'b0;
    rd(3, b); chk("R10 fail wins over write", b, 8'h95);
    wr(3, 8'h95); rd(3, b); chk("R10 write bit7=1 keeps", b, 8'h95);
    wr(3, 8'h15); rd(3, b); chk("R10 write bit7=0 clears", b, 8'h15);

    // R3 R11 minute wrap and strobe
    set_time(58, 59, 8'h10, 5, 2, 3, 21);
    tick1(); chk("R11 no strobe without wrap", minute_strobe, 1'b0);
    tick1(); chk("R11 strobe on wrap", minute_strobe, 1'b1);
    @(negedge clk); chk("R11 strobe one cycle", minute_strobe, 1'b0);
    rd_all(v); chk("R3 sec/min carry", v, pack(0, 0, 8'h11, 5, 2, 3, 21));

    // R4 R6 R8 full rollover
    set_time(59, 59, 8'h23, 31, 6, 12, 99);
    tick1(); rd_all(v); chk("R6 year 99 wrap, R8 weekday 6->0, R4", v, pack(0, 0, 8'h00, 1, 0, 1, 0));
    set_time(59, 59, 8'h23, 30, 1, 4, 10);
    tick1(); rd_all(v); chk("R6 30-day month", v, pack(0, 0, 8'h00, 1, 2, 5, 10));

    // R7 leap handling
    set_time(59, 59, 8'h23, 28, 3, 2, 24);
    tick1(); rd_all(v); chk("R7 leap Feb 28->29", v, pack(0, 0, 8'h00, 29, 4, 2, 24));
    tick1(); rd(6, b); chk("R7 no roll mid-day", b, 8'h29);
    set_time(59, 59, 8'h23, 29, 4, 2, 24);
    tick1(); rd_all(v); chk("R7 leap Feb 29->Mar 1", v, pack(0, 0, 8'h00, 1, 5, 3, 24));
    set_time(59, 59, 8'h23, 28, 0, 2, 23);
    tick1(); rd_all(v); chk("R7 common Feb 28->Mar 1", v, pack(0, 0, 8'h00, 1, 1, 3, 23));
    set_time(59, 59, 8'h23, 28, 0, 2, 0);
    tick1(); rd(6, b); chk("R7 year 00 leap", b, 8'h29);

    // R5 12-hour mode
    wr(0, 8'h08);
    set_time(59, 59, 8'h11, 5, 1, 6, 20);
    tick1(); rd(5, b); chk("R5 11AM->12PM", b, 8'h32);
    set_time(59, 59, 8'h32, 5, 1, 6, 20);
    tick1(); rd(5, b); chk("R5 12PM->1PM", b, 8'h21);
    set_time(59, 59, 8'h12, 5, 1, 6, 20);
    tick1(); rd(5, b); chk("R5 12AM->1AM", b, 8'h01);
    set_time(59, 59, 8'h31, 5, 1, 6, 20);
    tick1(); rd_all(v); chk("R5 11PM->12AM day carry, R8", v, pack(0, 0, 8'h12, 6, 2, 6, 20));
    wr(0, 8'h00);

    // R9 stop
    wr(0, 8'h20); wr(3, 8'h10);
    repeat (3) tick1();
    rd(3, b); chk("R9 stopped", b, 8'h10);
    wr(0, 8'h00); tick1(); rd(3, b); chk("R9 resumes", b, 8'h11);

    // R12 write during tick
    wr(3, 8'h20);
    @(negedge clk); addr = 5'd4; wdata = 8'h07; wr_en = 1'b1; tick_1hz = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_1hz = 1'b0;
    rd(3, b); chk("R12 tick dropped", b, 8'h20);
    rd(4, b); chk("R12 write applied", b, 8'h07);

    // R3 R4 R6 R7 R8 random 24-hour rollover cases
    for (int i = 0; i < 60; i++) begin
      int s, m, h, d, w, mo, y;
      mo = 1 + ($urandom % 12);
      y  = $urandom % 100;
      s  = ($urandom % 2) ? 59 : $urandom % 60;
      m  = ($urandom % 2) ? 59 : $urandom % 60;
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      d  = ($urandom % 2) ? mdays(mo, y) : 1 + ($urandom % mdays(mo, y));
      w  = $urandom % 7;
      set_time(s, m, to_bcd(h), d, w, mo, y);
      tick1();
      rd_all(v);
      s++;
      if (s == 60) begin s = 0; m++; end
      if (m == 60) begin m = 0; h++; end
      if (h == 24) begin
        h = 0; d++; w = (w + 1) % 7;
        if (d > mdays(mo, y)) begin d = 1; mo++; end
        if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
      end
      chk("R3/R4/R6/R7/R8 random step", v, pack(s, m, to_bcd(h), d, w, mo, y));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule